// File: doc/BRIEF.md
# Narrow-Port Register Mailbox Target

This block is the device end of a register mailbox on a simple 32-bit memory-mapped bus. The host does not get one address per word. It pushes every request word through one fixed data-in address and pulls every response word from one fixed data-out address, in strict program order. Request words collect in an internal buffer. A start bit in the control register hands the whole message, word by word, to a local consumer over a valid/ready stream. The consumer then posts a short result, an offset and three flag bits. The block presents that result as a fixed four-word reply.

The reply starts with a header word: object type in bits 31:16 and vendor identifier in bits 15:0, both parameters. The second word is the length 4, the third is the offset, and the fourth is the flags word: bit 0 success, bit 1 in progress, bit 2 error. The host reads a reply word and then writes to the data-out address to acknowledge it. The next word appears only after that write. A cancel bit in the control register returns the block to its empty collecting state at any time.

Register byte offsets: 0x0 control (bit 0 cancel, bit 31 start), 0x4 status (bit 31 reply ready, bit 2 error), 0x8 data-in, 0xC data-out. Control, data-in and any unmapped offset read as zero.

Top module: `mbox_narrow_target`

## Requirements
- R1: After reset, status reads 0, data-out reads 0 and the consumer stream is idle (request valid low, response ready low).
- R2: While collecting, each write to offset 0x8 appends one word. After start (control bit 31), the consumer stream delivers the words in arrival order, with last high on the final one. Data-in writes made after start, until the reply is fully acknowledged, are discarded.
- R3: A data-in write when DEPTH words are already buffered is discarded and sets status bit 2. The error bit stays set until cancel, and the stream carries only the first DEPTH words.
- R4: Status bit 31 rises once the consumer posts a result and stays high until the fourth reply word is acknowledged. Then it drops.
- R5: The reply words are, in order: {OBJ_TYPE, VENDOR_ID}, 4, the posted offset, and the posted 3-bit flags zero-extended.
- R6: Reading offset 0xC never advances the reply, and repeated reads return the same word. Only a write to offset 0xC moves to the next word.
- R7: Offset 0xC reads 0 whenever no reply word is pending.
- R8: A control write with bit 0 set empties the buffer, drops the reply, clears the error and the ready bits, and returns to collecting. It takes priority over bit 31 in the same write.
- R9: Start with an empty buffer skips the stream. The request valid stays low and the block waits directly for the consumer's result (response ready high).
- R10: While request ready is low, request valid, data and last hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the read strobe, zero otherwise |
| cons_req_valid | output | 1 | Request word offered to the consumer |
| cons_req_ready | input | 1 | Consumer takes the offered word |
| cons_req_data | output | 32 | Offered request word |
| cons_req_last | output | 1 | Offered word is the final one |
| cons_rsp_ready | output | 1 | Block is waiting for the consumer's result |
| cons_rsp_valid | input | 1 | Consumer posts its result |
| cons_rsp_offset | input | 32 | Offset value for the reply |
| cons_rsp_flags | input | 3 | Success, in-progress and error flags for the reply |

## Verification
The bench builds the block with DEPTH set to 4 and a vendor identifier of 0xA5C3, with the default object type 0xB. The small depth lets a six-word burst hit the full boundary, so the discard, the sticky error bit and the truncated stream are all exercised with short sequences. The non-default vendor identifier makes the header word check sensitive to field placement. A cancel issued during streaming, a start on an empty buffer and a stalled consumer round out the control paths.

// File: rtl/mbox_pkg.sv
// Package: shared constants and the state type of the narrow-port mailbox.
// Assumes a 32-bit register bus with byte offsets.
package mbox_pkg;

    localparam int DW = 32;

    // Byte offsets of the four registers.
    localparam logic [31:0] OFF_CTRL = 32'h0;
    localparam logic [31:0] OFF_STS  = 32'h4;
    localparam logic [31:0] OFF_WR   = 32'h8;
    localparam logic [31:0] OFF_RD   = 32'hC;

    // Bit positions inside control and status.
    localparam int CTRL_CANCEL_BIT = 0;
    localparam int CTRL_START_BIT  = 31;
    localparam int STS_READY_BIT   = 31;
    localparam int STS_ERR_BIT     = 2;

    // Fixed reply size in words.
    localparam int RSP_WORDS = 4;
    localparam int RSP_IDX_W = $clog2(RSP_WORDS);

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_SEND    = 2'd1,
        ST_WAIT    = 2'd2,
        ST_RESP    = 2'd3
    } mbox_state_e;

endpackage

// File: rtl/mbox_reg_decode.sv
// Module: address decode and read multiplexer of the mailbox registers.
// Turns bus writes into one-cycle command strobes and assembles read data.
// Assumes at most one of read or write per cycle; reads have no side effect.
module mbox_reg_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              sts_ready,
    input  logic              sts_error,
    input  logic              rsp_valid,
    input  logic [DW-1:0]     rsp_word,
    output logic              cancel_p,
    output logic              start_p,
    output logic              push_p,
    output logic              ack_p,
    output logic [DW-1:0]     bus_rdata
);

    logic sel_ctrl, sel_sts, sel_wr, sel_rd;

    // Purpose: match the access offset against each register.
    always_comb begin
        sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
        sel_sts  = (bus_addr == ADDR_W'(OFF_STS));
        sel_wr   = (bus_addr == ADDR_W'(OFF_WR));
        sel_rd   = (bus_addr == ADDR_W'(OFF_RD));
    end

    // Purpose: derive write strobes; cancel wins over start.
    always_comb begin
        cancel_p = bus_wr_en && sel_ctrl && bus_wdata[CTRL_CANCEL_BIT];
        start_p  = bus_wr_en && sel_ctrl && bus_wdata[CTRL_START_BIT]
                   && !bus_wdata[CTRL_CANCEL_BIT];
        push_p   = bus_wr_en && sel_wr;
        ack_p    = bus_wr_en && sel_rd;
    end

    // Purpose: read multiplexer; zero for write-only and unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en) begin
            if (sel_sts) begin
                bus_rdata[STS_READY_BIT] = sts_ready;
                bus_rdata[STS_ERR_BIT]   = sts_error;
            end else if (sel_rd && rsp_valid) begin
                bus_rdata = rsp_word;
            end
        end
    end

endmodule

// File: rtl/mbox_req_buf.sv
// Module: in-order request store of the mailbox.
// Appends words at a write count and reads them out from a separate pointer.
// Assumes the caller never pushes when full and only pops while words remain.
module mbox_req_buf
    import mbox_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head_data,
    output logic             head_last,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0]    mem_q [DEPTH];
    logic [CNT_W-1:0] wr_cnt_q;
    logic [CNT_W-1:0] rd_ptr_q;

    // One storage word per entry, written when the count points at it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Purpose: capture a pushed word into entry g.
        always_ff @(posedge clk) begin
            if (push && (wr_cnt_q == CNT_W'(g))) begin
                mem_q[g] <= push_data;
            end
        end
    end

    // Purpose: advance the write count and read pointer, or empty the store.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_cnt_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (push) wr_cnt_q <= wr_cnt_q + CNT_W'(1);
            if (pop)  rd_ptr_q <= rd_ptr_q + CNT_W'(1);
        end
    end

    // Purpose: present the word at the read pointer and its flags.
    always_comb begin
        head_data = mem_q[rd_ptr_q[IDX_W-1:0]];
        head_last = (CNT_W'(rd_ptr_q + CNT_W'(1)) == wr_cnt_q);
        full      = (wr_cnt_q == CNT_W'(DEPTH));
        count     = wr_cnt_q;
    end

    // R3: the count never passes the depth, and no push lands on a full store.
    assert_no_overflow_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt_q <= CNT_W'(DEPTH)) && !(push && full));

    // R2: reads never run ahead of writes.
    assert_order_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (rd_ptr_q < wr_cnt_q));

endmodule

// File: rtl/mbox_rsp_seq.sv
// Module: four-word reply sequencer of the mailbox.
// Captures the consumer's result and steps through the reply words on acknowledge.
// Assumes load arrives only while no reply is pending.
module mbox_rsp_seq
    import mbox_pkg::*;
#(
    parameter logic [15:0] OBJ_TYPE  = 16'h000B,
    parameter logic [15:0] VENDOR_ID = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] load_offset,
    input  logic [2:0]    load_flags,
    input  logic          ack,
    output logic          valid,
    output logic [DW-1:0] word,
    output logic          last_ack
);

    logic                 valid_q;
    logic [RSP_IDX_W-1:0] idx_q;
    logic [DW-1:0]        off_q;
    logic [2:0]           flags_q;

    // Purpose: flag the acknowledge of the final reply word.
    always_comb begin
        last_ack = ack && valid_q && (idx_q == RSP_IDX_W'(RSP_WORDS - 1));
    end

    // Purpose: capture the result, step the word index on acknowledge, retire at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            off_q   <= '0;
            flags_q <= '0;
        end else if (load && !valid_q) begin
            valid_q <= 1'b1;
            idx_q   <= '0;
            off_q   <= load_offset;
            flags_q <= load_flags;
        end else if (last_ack) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else if (ack && valid_q) begin
            idx_q   <= idx_q + RSP_IDX_W'(1);
        end
    end

    // Purpose: select the reply word at the current index.
    always_comb begin
        case (idx_q)
            RSP_IDX_W'(0): word = {OBJ_TYPE, VENDOR_ID};
            RSP_IDX_W'(1): word = DW'(RSP_WORDS);
            RSP_IDX_W'(2): word = off_q;
            default:       word = {{(DW-3){1'b0}}, flags_q};
        endcase
        valid = valid_q;
    end

    // R6: without an acknowledge the presented word holds.
    assert_word_stable_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ack && !clear) |=> (valid_q && $stable(word)));

endmodule

// File: rtl/mbox_narrow_target.sv
// Module: top of the narrow-port register mailbox target.
// Sequences collect -> stream to consumer -> wait for result -> reply readout.
// Assumes one bus access per cycle; cancel may arrive in any state.
module mbox_narrow_target
    import mbox_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int          DEPTH     = 16,
    parameter logic [15:0] OBJ_TYPE  = 16'h000B,
    parameter logic [15:0] VENDOR_ID = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cons_req_valid,
    input  logic              cons_req_ready,
    output logic [31:0]       cons_req_data,
    output logic              cons_req_last,
    output logic              cons_rsp_ready,
    input  logic              cons_rsp_valid,
    input  logic [31:0]       cons_rsp_offset,
    input  logic [2:0]        cons_rsp_flags
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    mbox_state_e      state_q;
    logic             err_q;
    logic             cancel_p, start_p, push_p, ack_p;
    logic             buf_push, buf_pop, buf_clear, buf_full, buf_last;
    logic [CNT_W-1:0] buf_count;
    logic [DW-1:0]    buf_head;
    logic             rsp_load, rsp_valid, rsp_last_ack;
    logic [DW-1:0]    rsp_word;

    mbox_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sts_ready (rsp_valid),
        .sts_error (err_q),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .cancel_p  (cancel_p),
        .start_p   (start_p),
        .push_p    (push_p),
        .ack_p     (ack_p),
        .bus_rdata (bus_rdata)
    );

    mbox_req_buf #(.DEPTH(DEPTH)) u_req_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .push      (buf_push),
        .push_data (bus_wdata),
        .pop       (buf_pop),
        .head_data (buf_head),
        .head_last (buf_last),
        .full      (buf_full),
        .count     (buf_count)
    );

    mbox_rsp_seq #(.OBJ_TYPE(OBJ_TYPE), .VENDOR_ID(VENDOR_ID)) u_rsp_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cancel_p),
        .load        (rsp_load),
        .load_offset (cons_rsp_offset),
        .load_flags  (cons_rsp_flags),
        .ack         (ack_p),
        .valid       (rsp_valid),
        .word        (rsp_word),
        .last_ack    (rsp_last_ack)
    );

    // Purpose: gate buffer and reply controls by the current phase.
    always_comb begin
        buf_push  = push_p && (state_q == ST_COLLECT) && !buf_full && !cancel_p;
        buf_pop   = (state_q == ST_SEND) && cons_req_ready && !cancel_p;
        buf_clear = cancel_p || rsp_last_ack;
        rsp_load  = (state_q == ST_WAIT) && cons_rsp_valid && !cancel_p;
    end

    // Purpose: drive the consumer-side handshake outputs.
    always_comb begin
        cons_req_valid = (state_q == ST_SEND);
        cons_req_data  = buf_head;
        cons_req_last  = buf_last;
        cons_rsp_ready = (state_q == ST_WAIT);
    end

    // Purpose: phase sequencer with cancel taking priority in every state.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel_p) begin
            state_q <= ST_COLLECT;
        end else begin
            case (state_q)
                ST_COLLECT: if (start_p)
                                state_q <= (buf_count == '0) ? ST_WAIT : ST_SEND;
                ST_SEND:    if (buf_pop && buf_last) state_q <= ST_WAIT;
                ST_WAIT:    if (rsp_load) state_q <= ST_RESP;
                ST_RESP:    if (rsp_last_ack) state_q <= ST_COLLECT;
                default:    state_q <= ST_COLLECT;
            endcase
        end
    end

    // Purpose: sticky error on a push into a full buffer, cleared by cancel.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel_p) begin
            err_q <= 1'b0;
        end else if (push_p && (state_q == ST_COLLECT) && buf_full) begin
            err_q <= 1'b1;
        end
    end

    // R4: ready holds until the final reply word is acknowledged.
    assert_ready_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last_ack && !cancel_p) |=> rsp_valid);

    // R4: ready is only shown in the reply phase.
    assert_ready_phase_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (state_q == ST_RESP));

    // R7: data-out reads zero when no reply word is pending.
    assert_idle_rdata_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && (bus_addr == ADDR_W'(OFF_RD)) && !rsp_valid) |-> (bus_rdata == '0));

    // R8: cancel leaves an empty, idle, error-free block.
    assert_cancel_clears_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        cancel_p |=> (!cons_req_valid && !rsp_valid && !err_q && (buf_count == '0)));

    // R10: a stalled offer holds its word and last flag.
    assert_stream_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (cons_req_valid && !cons_req_ready && !cancel_p) |=>
        (cons_req_valid && $stable(cons_req_data) && $stable(cons_req_last)));

endmodule

// File: tb/mbox_narrow_target_tb.sv
`timescale 1ns/1ps
module mbox_narrow_target_tb;

    localparam int          ADDR_W = 4;
    localparam int          DEPTH  = 4;
    localparam logic [15:0] OBJ    = 16'h000B;
    localparam logic [15:0] VID    = 16'hA5C3;
    localparam logic [31:0] HDR    = {OBJ, VID};
    localparam logic [31:0] A_CTRL = 32'h0, A_STS = 32'h4, A_WR = 32'h8, A_RD = 32'hC;
    localparam logic [31:0] S_READY = 32'h8000_0000, S_ERR = 32'h0000_0004;
    localparam logic [31:0] C_START = 32'h8000_0000, C_CANCEL = 32'h0000_0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0, bus_rdata;
    logic              cons_req_valid, cons_req_last, cons_rsp_ready;
    logic              cons_req_ready = 1'b0, cons_rsp_valid = 1'b0;
    logic [31:0]       cons_req_data, cons_rsp_offset = '0;
    logic [2:0]        cons_rsp_flags = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mbox_narrow_target #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .OBJ_TYPE(OBJ), .VENDOR_ID(VID)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cons_req_valid(cons_req_valid), .cons_req_ready(cons_req_ready),
        .cons_req_data(cons_req_data), .cons_req_last(cons_req_last),
        .cons_rsp_ready(cons_rsp_ready), .cons_rsp_valid(cons_rsp_valid),
        .cons_rsp_offset(cons_rsp_offset), .cons_rsp_flags(cons_rsp_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[ADDR_W-1:0]; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[ADDR_W-1:0]; bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    // Take n words from the stream and compare them with the expected list.
    task automatic take_stream(input int n, input logic [31:0] exp [8], input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({req, " stream valid"}, 32'(cons_req_valid), 32'd1);
            chk({req, " stream data"}, cons_req_data, exp[i]);
            chk({req, " stream last"}, 32'(cons_req_last), 32'(i == n - 1));
            cons_req_ready = 1'b1;
        end
        @(negedge clk);
        cons_req_ready = 1'b0;
        chk({req, " stream done"}, 32'(cons_req_valid), 32'd0);
    endtask

    task automatic post_result(input logic [31:0] off, input logic [2:0] fl);
        @(negedge clk);
        chk("R9 rsp ready while waiting", 32'(cons_rsp_ready), 32'd1);
        cons_rsp_valid = 1'b1; cons_rsp_offset = off; cons_rsp_flags = fl;
        @(negedge clk);
        cons_rsp_valid = 1'b0;
    endtask

    // Read and acknowledge the four reply words.
    task automatic drain_reply(input logic [31:0] off, input logic [2:0] fl);
        logic [31:0] d;
        logic [31:0] exp [4];
        exp[0] = HDR; exp[1] = 32'd4; exp[2] = off; exp[3] = {29'd0, fl};
        for (int i = 0; i < 4; i++) begin
            rd(A_STS, d);
            chk("R4 ready before final ack", d & S_READY, S_READY);
            rd(A_RD, d);
            chk("R5 reply word", d, exp[i]);
            rd(A_RD, d);
            chk("R6 reread holds", d, exp[i]);
            wr(A_RD, 32'd0);
        end
        rd(A_STS, d);
        chk("R4 ready drops after final ack", d & S_READY, 32'd0);
        rd(A_RD, d);
        chk("R7 data-out zero after reply", d, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STS, d);
        chk("R1 status after reset", d, 32'd0);
        rd(A_RD, d);
        chk("R1 R7 data-out after reset", d, 32'd0);
        chk("R1 req valid after reset", 32'(cons_req_valid), 32'd0);
        chk("R1 rsp ready after reset", 32'(cons_rsp_ready), 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        logic [31:0] exp [8];
        exp[0] = 32'h000B_1111; exp[1] = 32'd5; exp[2] = 32'd3; exp[3] = 32'd0;
        for (int i = 4; i < 8; i++) exp[i] = '0;
        for (int i = 0; i < 4; i++) wr(A_WR, exp[i]);
        rd(A_STS, d);
        chk("R3 no error at exact depth", d, 32'd0);
        wr(A_CTRL, C_START);
        // R10: consumer stalls for three cycles.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 stalled valid", 32'(cons_req_valid), 32'd1);
            chk("R10 stalled data", cons_req_data, exp[0]);
        end
        take_stream(4, exp, "R2");
        wr(A_WR, 32'hDEAD_BEEF);   // R2: discarded while in flight
        post_result(32'h0000_1000, 3'b001);
        drain_reply(32'h0000_1000, 3'b001);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        logic [31:0] exp [8];
        for (int i = 0; i < 8; i++) exp[i] = 32'h7000_0000 + 32'(i);
        rd(A_STS, d);
        chk("R2 late write left no error", d, 32'd0);
        for (int i = 0; i < 6; i++) wr(A_WR, exp[i]);
        rd(A_STS, d);
        chk("R3 error on overflow", d, S_ERR);
        wr(A_CTRL, C_START);
        take_stream(DEPTH, exp, "R3");
        post_result(32'hCAFE_0000, 3'b010);
        drain_reply(32'hCAFE_0000, 3'b010);
        rd(A_STS, d);
        chk("R3 error sticky", d, S_ERR);
        wr(A_CTRL, C_CANCEL);
        rd(A_STS, d);
        chk("R8 cancel clears error", d, 32'd0);
    endtask

    task automatic t_cancel();
        logic [31:0] d;
        logic [31:0] exp [8];
        for (int i = 0; i < 8; i++) exp[i] = '0;
        wr(A_WR, 32'h1);
        wr(A_WR, 32'h2);
        wr(A_CTRL, C_START);
        @(negedge clk);
        chk("R8 streaming before cancel", 32'(cons_req_valid), 32'd1);
        wr(A_CTRL, C_START | C_CANCEL);
        chk("R8 stream idle after cancel", 32'(cons_req_valid), 32'd0);
        rd(A_STS, d);
        chk("R8 status after cancel", d, 32'd0);
        exp[0] = 32'h0000_00AA;
        wr(A_WR, exp[0]);
        wr(A_CTRL, C_START);
        take_stream(1, exp, "R8");
        post_result(32'h5, 3'b001);
        drain_reply(32'h5, 3'b001);
    endtask

    task automatic t_empty_start();
        logic [31:0] exp [8];
        for (int i = 0; i < 8; i++) exp[i] = '0;
        wr(A_CTRL, C_START);
        @(negedge clk);
        chk("R9 no stream on empty start", 32'(cons_req_valid), 32'd0);
        chk("R9 waits for result", 32'(cons_rsp_ready), 32'd1);
        wr(A_WR, 32'hBAD0_0001);   // R2: discarded while waiting
        post_result(32'hFFFF_FFFF, 3'b100);
        drain_reply(32'hFFFF_FFFF, 3'b100);
        exp[0] = 32'h1234_5678;
        wr(A_WR, exp[0]);
        wr(A_CTRL, C_START);
        take_stream(1, exp, "R2 fresh");
        post_result(32'h0, 3'b000);
        drain_reply(32'h0, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_overflow();
        t_cancel();
        t_empty_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule